// File: doc/BRIEF.md
# Modified Immediate Constant Expander

This block turns the immediate field of a data-processing instruction word into a 32-bit operand and the carry that a following shift or logic operation would see. It understands two field layouts, chosen per request by a mode input. In the fixed-width layout, a byte is rotated right by an even amount. In the compact layout, a 12-bit field is gathered from scattered instruction bits. That field either replicates a byte in one of four patterns or rotates a byte whose top bit is implied to be one.

Besides the expanded constant, a select input can return three plain forms of the immediate: the gathered 12-bit field zero-extended, a 7-bit field scaled by four, and a byte scaled by four. A status output flags replication patterns whose byte is zero. A parameter chooses between a registered result, captured on an input strobe and presented one cycle later, and a purely combinational path. Decoding which instruction is present is left to the surrounding logic.

Top module: `imm_expander`

## Requirements
- R1: With `wide_mode`=0 and `imm_sel`=0, `imm_out` is `instr[7:0]` zero-extended to 32 bits and rotated right by 2×`instr[11:8]`.
- R2: With `wide_mode`=0 and `imm_sel`=0, `carry_out` equals `carry_in` when `instr[11:8]` is zero; otherwise it equals bit 31 of `imm_out`.
- R3: In the compact layout the 12-bit field F is {`instr[26]`, `instr[14:12]`, `instr[7:0]`}, with `instr[26]` as F[11].
- R4: With `wide_mode`=1, `imm_sel`=0 and F[11:10]=0, F[9:8] picks the pattern for byte B=F[7:0]: 0 gives B zero-extended, 1 gives B in bytes 0 and 2, 2 gives B in bytes 1 and 3, 3 gives B in all four bytes; `carry_out` equals `carry_in`.
- R5: With `wide_mode`=1, `imm_sel`=0 and F[11:10]≠0, `imm_out` is the byte {1, F[6:0]} rotated right by F[11:7], and `carry_out` is bit 31 of `imm_out`.
- R6: `unpred` is 1 exactly when `wide_mode`=1, `imm_sel`=0, F[11:10]=0, F[9:8]≠0 and B=0; `imm_out` is then zero.
- R7: `imm_sel`=1 gives F zero-extended, `imm_sel`=2 gives `instr[6:0]`×4, `imm_sel`=3 gives `instr[7:0]`×4; for these `carry_out` equals `carry_in` and `unpred` is 0, whatever `wide_mode` is.
- R8: With REG_OUT=1, a request with `in_valid`=1 is captured at a clock edge and shown with `out_valid`=1 after it; `out_valid` is 0 after any edge where `in_valid` was 0, and the result outputs then hold their previous values.
- R9: Synchronous active-high `rst` clears `out_valid`, `imm_out`, `carry_out` and `unpred` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| wide_mode | input | 1 | 0 fixed-width layout, 1 compact layout |
| imm_sel | input | 2 | 0 expanded, 1 zero-extended field, 2 7-bit×4, 3 byte×4 |
| carry_in | input | 1 | Incoming carry flag |
| imm_out | output | 32 | 32-bit immediate |
| carry_out | output | 1 | Carry produced by the expansion |
| unpred | output | 1 | Zero byte in a replicating pattern |
| out_valid | output | 1 | Result valid |

## Verification
The bench aims at the zero-rotation case of the fixed layout, where a design that always took bit 31 would lose the incoming carry. It drives each compact replication pattern with a patterned byte and with a zero byte, so that a swapped byte lane, a missing status flag or a status flag raised for pattern 0 shows up. It sets instruction bit 26 alone to catch a field gathered in the wrong order, which would give a wrong rotation amount. It also sends strobe-free cycles with new inputs, which a register that loads every cycle would leak to the outputs.

// File: rtl/imm_expand_pkg.sv
package imm_expand_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int FIELD_W = 12;
    localparam int ROT_W   = $clog2(WORD_W);

    typedef enum logic {
        ENC_FIXED   = 1'b0,
        ENC_COMPACT = 1'b1
    } enc_mode_e;

    typedef enum logic [1:0] {
        SEL_EXPAND = 2'd0,
        SEL_ZEXT12 = 2'd1,
        SEL_SCALE7 = 2'd2,
        SEL_SCALE8 = 2'd3
    } imm_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              carry;
        logic              unpred;
    } imm_res_t;

    function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] v,
                                               input logic [ROT_W-1:0]  amt);
        logic [2*WORD_W-1:0] dbl;
        dbl = {v, v} >> amt;
        return dbl[WORD_W-1:0];
    endfunction

    // R3: scattered field gather, bit 26 lands on the field MSB
    function automatic logic [FIELD_W-1:0] gather_field(input logic [WORD_W-1:0] iw);
        return {iw[26], iw[14:12], iw[7:0]};
    endfunction

endpackage

// File: rtl/imm_fixed_expand.sv
module imm_fixed_expand
    import imm_expand_pkg::*;
(
    input  logic [WORD_W-1:0] instr_word,
    input  logic              carry_in,
    output imm_res_t          res
);
    logic [ROT_W-1:0]  rot_amt;
    logic [WORD_W-1:0] base;

    always_comb begin
        rot_amt    = {instr_word[11:8], 1'b0};
        base       = {{(WORD_W-BYTE_W){1'b0}}, instr_word[BYTE_W-1:0]};
        res.value  = rotr(base, rot_amt);
        res.carry  = (rot_amt == '0) ? carry_in : res.value[WORD_W-1];   // R2
        res.unpred = 1'b0;
    end

    // R1: a rotation keeps the number of set bits of the byte
    always_comb begin
        p_popcount_r1: assert ($countones(res.value) == $countones(instr_word[BYTE_W-1:0]))
            else $error("fixed rotate changed popcount");
    end
endmodule

// File: rtl/imm_compact_expand.sv
module imm_compact_expand
    import imm_expand_pkg::*;
(
    input  logic [WORD_W-1:0] instr_word,
    input  logic              carry_in,
    output imm_res_t          res
);
    logic [FIELD_W-1:0] fld;
    logic [BYTE_W-1:0]  bval;
    logic               is_rot;

    always_comb begin
        fld        = gather_field(instr_word);
        bval       = fld[BYTE_W-1:0];
        is_rot     = (fld[11:10] != 2'b00);
        res.unpred = 1'b0;
        res.carry  = carry_in;
        if (is_rot) begin
            // R5: implied leading one, rotate by the top five field bits
            res.value = rotr({{(WORD_W-BYTE_W){1'b0}}, 1'b1, fld[6:0]}, fld[11:7]);
            res.carry = res.value[WORD_W-1];
        end else begin
            // R4: byte replication patterns
            unique case (fld[9:8])
                2'd0:    res.value = {24'h0, bval};
                2'd1:    res.value = {8'h0, bval, 8'h0, bval};
                2'd2:    res.value = {bval, 8'h0, bval, 8'h0};
                default: res.value = {bval, bval, bval, bval};
            endcase
            res.unpred = (fld[9:8] != 2'd0) && (bval == '0);   // R6
        end
    end

    always_comb begin
        if (is_rot) begin
            p_implied_one_r5: assert ($countones(res.value) == $countones(fld[6:0]) + 1)
                else $error("rotated constant lost its implied bit");
        end else begin
            p_pattern_weight_r4: assert ($countones(res.value) ==
                                         $countones(bval) * ((fld[9:8] == 2'd0) ? 1 :
                                                             (fld[9:8] == 2'd3) ? 4 : 2))
                else $error("replication pattern weight wrong");
        end
    end
endmodule

// File: rtl/imm_plain_select.sv
module imm_plain_select
    import imm_expand_pkg::*;
(
    input  logic [WORD_W-1:0] instr_word,
    input  logic [1:0]        sel,
    input  logic              carry_in,
    input  logic              wide,
    input  imm_res_t          fixed_res,
    input  imm_res_t          compact_res,
    output imm_res_t          res
);
    always_comb begin
        res.carry  = carry_in;
        res.unpred = 1'b0;
        unique case (imm_sel_e'(sel))
            SEL_EXPAND: res = (enc_mode_e'(wide) == ENC_COMPACT) ? compact_res : fixed_res;
            SEL_ZEXT12: res.value = {{(WORD_W-FIELD_W){1'b0}}, gather_field(instr_word)};
            SEL_SCALE7: res.value = {{(WORD_W-9){1'b0}}, instr_word[6:0], 2'b00};
            default:    res.value = {{(WORD_W-10){1'b0}}, instr_word[7:0], 2'b00};
        endcase
    end

    // R7: plain forms never touch the carry and never flag status
    always_comb begin
        if (sel != 2'd0) begin
            p_plain_flags_r7: assert (res.carry == carry_in && !res.unpred)
                else $error("plain immediate altered flags");
        end
    end
endmodule

// File: rtl/imm_expander.sv
module imm_expander
    import imm_expand_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic              wide_mode,
    input  logic [1:0]        imm_sel,
    input  logic              carry_in,
    output logic [WORD_W-1:0] imm_out,
    output logic              carry_out,
    output logic              unpred,
    output logic              out_valid
);
    imm_res_t fixed_res, compact_res, sel_res, res_q;
    logic     vld_q;

    imm_fixed_expand u_fixed (
        .instr_word (instr),
        .carry_in   (carry_in),
        .res        (fixed_res)
    );

    imm_compact_expand u_compact (
        .instr_word (instr),
        .carry_in   (carry_in),
        .res        (compact_res)
    );

    imm_plain_select u_select (
        .instr_word  (instr),
        .sel         (imm_sel),
        .carry_in    (carry_in),
        .wide        (wide_mode),
        .fixed_res   (fixed_res),
        .compact_res (compact_res),
        .res         (sel_res)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) res_q <= sel_res;
                end
            end

            p_valid_next_r8: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> (!out_valid && $stable(imm_out) && $stable(carry_out)));
            p_unpred_zero_r6: assert property (@(posedge clk) disable iff (rst)
                unpred |-> (imm_out == '0));
            p_plain_carry_r7: assert property (@(posedge clk) disable iff (rst)
                (in_valid && imm_sel != 2'd0) |=> (carry_out == $past(carry_in) && !unpred));
        end else begin : g_comb
            assign res_q = sel_res;
            assign vld_q = in_valid;
        end
    endgenerate

    assign imm_out   = res_q.value;
    assign carry_out = res_q.carry;
    assign unpred    = res_q.unpred;
    assign out_valid = vld_q;
endmodule

// File: tb/imm_expander_bench.sv
module imm_expander_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        wide_mode = 1'b0;
    logic [1:0]  imm_sel = '0;
    logic        carry_in = 1'b0;
    logic [31:0] imm_out;
    logic        carry_out, unpred, out_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    imm_expander u_imm_expander (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .wide_mode(wide_mode), .imm_sel(imm_sel), .carry_in(carry_in),
        .imm_out(imm_out), .carry_out(carry_out), .unpred(unpred), .out_valid(out_valid)
    );

    function automatic logic [31:0] ref_ror(input logic [31:0] v, input int amt);
        int a;
        a = amt % 32;
        if (a == 0) return v;
        return (v >> a) | (v << (32 - a));
    endfunction

    // expected {imm, carry, unpred} from the requirements
    function automatic logic [33:0] model(input logic [31:0] iw, input logic wm,
                                          input logic [1:0] s, input logic ci);
        logic [11:0] f;
        logic [7:0]  b;
        logic [31:0] v;
        logic        c, u;
        f = {iw[26], iw[14:12], iw[7:0]};
        b = f[7:0];
        c = ci;
        u = 1'b0;
        if (s == 2'd1)      v = {20'h0, f};
        else if (s == 2'd2) v = {23'h0, iw[6:0]} * 4;
        else if (s == 2'd3) v = {24'h0, iw[7:0]} * 4;
        else if (!wm) begin
            v = ref_ror({24'h0, iw[7:0]}, 2 * iw[11:8]);
            if (iw[11:8] != 0) c = v[31];
        end else if (f[11:10] != 0) begin
            v = ref_ror({24'h0, 1'b1, f[6:0]}, f[11:7]);
            c = v[31];
        end else begin
            case (f[9:8])
                2'd0: v = {24'h0, b};
                2'd1: v = {8'h0, b, 8'h0, b};
                2'd2: v = {b, 8'h0, b, 8'h0};
                default: v = {b, b, b, b};
            endcase
            u = (f[9:8] != 0) && (b == 0);
        end
        return {v, c, u};
    endfunction

    task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got imm=%h c=%b u=%b, expected imm=%h c=%b u=%b",
                     req, got[33:2], got[1], got[0], exp[33:2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(input string req, input logic [31:0] iw, input logic wm,
                         input logic [1:0] s, input logic ci);
        @(negedge clk);
        instr = iw; wide_mode = wm; imm_sel = s; carry_in = ci; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {imm_out, carry_out, unpred}, model(iw, wm, s, ci));
        check({req, " valid R8"}, {33'h0, out_valid}, 34'h1);
    endtask

    initial begin
        logic [33:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R9 reset", {imm_out, carry_out, unpred}, 34'h0);
        check("R9 reset valid", {33'h0, out_valid}, 34'h0);
        rst = 1'b0;

        // R1/R2 fixed-width
        apply("R2 zero rotate keeps carry", 32'h0000_00FF, 1'b0, 2'd0, 1'b1);
        apply("R1 rotate by 2", 32'h0000_0103, 1'b0, 2'd0, 1'b0);   // C0000000, carry 1
        check("R1 direct", {imm_out, carry_out, unpred}, {32'hC000_0000, 1'b1, 1'b0});
        apply("R1 rotate by 30", 32'h0000_0F81, 1'b0, 2'd0, 1'b1);
        // R4 patterns
        apply("R4 pattern 0", 32'h0000_00A5, 1'b1, 2'd0, 1'b1);
        apply("R4 pattern 1", 32'h0000_10A5, 1'b1, 2'd0, 1'b0);
        check("R4 direct p1", {imm_out, carry_out, unpred}, {32'h00A5_00A5, 1'b0, 1'b0});
        apply("R4 pattern 2", 32'h0000_20A5, 1'b1, 2'd0, 1'b1);
        apply("R4 pattern 3", 32'h0000_30A5, 1'b1, 2'd0, 1'b0);
        // R6 status
        apply("R6 zero byte pattern 2", 32'h0000_2000, 1'b1, 2'd0, 1'b1);
        check("R6 direct", {imm_out, carry_out, unpred}, {32'h0, 1'b1, 1'b1});
        apply("R6 zero byte pattern 0", 32'h0000_0000, 1'b1, 2'd0, 1'b0);
        // R3/R5 bit 26 alone: F=0x800, rotate {1,0000000} by 16
        apply("R3 R5 bit26 gather", 32'h0400_0000, 1'b1, 2'd0, 1'b0);
        check("R5 direct", {imm_out, carry_out, unpred}, {32'h0080_0000, 1'b0, 1'b0});
        apply("R5 rotate by 8", 32'h0000_4000, 1'b1, 2'd0, 1'b0);   // 80000000 carry 1
        check("R5 carry direct", {imm_out, carry_out, unpred}, {32'h8000_0000, 1'b1, 1'b0});
        // R7 plain forms
        apply("R7 zext12", 32'h0400_7FFF, 1'b0, 2'd1, 1'b1);
        apply("R7 scale7", 32'hFFFF_FFFF, 1'b1, 2'd2, 1'b0);
        apply("R7 scale8", 32'hFFFF_2000, 1'b1, 2'd3, 1'b1);

        // R8 hold: new inputs without strobe
        held = {imm_out, carry_out, unpred};
        @(negedge clk);
        instr = 32'h1234_5678; wide_mode = 1'b0; imm_sel = 2'd0; carry_in = ~carry_in;
        @(negedge clk);
        check("R8 hold without strobe", {imm_out, carry_out, unpred}, held);
        check("R8 valid low", {33'h0, out_valid}, 34'h0);

        for (int i = 0; i < 1500; i++) begin
            logic [31:0] rw;
            rw = $urandom();
            case (i % 4)
                0: apply("R1 R2 random", rw, 1'b0, 2'd0, rw[31]);
                1: apply("R4 R5 R6 random", rw, 1'b1, 2'd0, rw[30]);
                2: apply("R4 R6 random patterns", rw & 32'hFBFF_33FF & ((i % 8 == 2) ? 32'hFFFF_FF00 : 32'hFFFF_FFFF), 1'b1, 2'd0, rw[29]);
                default: apply("R7 random", rw, rw[28], rw[27:26] | 2'd1, rw[25]);
            endcase
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule